// File: doc/BRIEF.md
# Segmented Unit-Stride Vector Access Sequencer

This block walks through the element accesses of one unit-stride vector load or store. Each element can carry from 1 to 8 segment fields that sit next to each other in memory. A start pulse captures the operation: base address, active length, element width code, group multiplier code, field count, mask enable, memory access width, signedness and direction. The block also captures a snapshot of the mask register. It then issues one memory request per active element field over a valid/ready handshake.

For loads, each response is sign- or zero-extended to the element width and written to a vector register file write port. The register file holds each field in its own register group, and the groups are spaced one maximum vector length apart. After the body of a load, the block writes zero to every element past the active length in each field. For stores, the block reads the element from a register file read port that has one cycle of latency. It then sends only the low bits of that element that the memory width covers.

Address translation, permission faults and the register file storage are handled by the surrounding pipeline.

Top module: `vseg_access_seq`

## Requirements
- R1: Requests go out element by element, with fields in order inside each element. The request for element i, field k carries address base + (i*F + k)*B, where F is the field count (the `seg_count_m1` input plus 1) and B is 2^`mem_size` bytes. `mem_req_size` equals `mem_size` (0=1, 1=2, 2=4, 3=8 bytes), and `mem_req_write` is 1 for a store.
- R2: Field k of element i uses register file index i + k*VMAX, for both writes and store reads.
- R3: VMAX = ((VLEN/8) << `lmul_code`) >> `sew_code`. Element width is 8 << `sew_code` bits.
- R4: When vl is 0, `done` is high in the cycle after start. No memory request and no register write occur.
- R5: With `use_mask`=0, element i is skipped for all of its fields when bit i*M of the mask snapshot is 0, where M = 2^(`sew_code` + 3 - `lmul_code`). A skipped element produces no request and its register entries keep their old values. With `use_mask`=1, every element below vl is active.
- R6: After a load body, indices vl..VMAX-1 of every field are written with zero. A store writes no register entry.
- R7: Load data keeps the low B bytes of the response. It is sign-extended when `load_signed`=1 and zero-extended otherwise, then cut to the element width. Bits above the element width are zero.
- R8: Store write data holds the low B bytes of the element, and all higher bits are zero.
- R9: At most one request is outstanding. While `mem_req_valid` is high and `mem_req_ready` is low, the address, size and data stay unchanged.
- R10: `done` is a one-cycle pulse. It comes one cycle after the last tail write of a load, or one cycle after the last accepted request of a store whose final element is active. A start that arrives while `busy` is high is ignored.
- R11: Store data comes from the register file read port. The index uses the R2 mapping, and the data is sampled one cycle after `rf_rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (sampled while idle) |
| base_addr | input | ADDR_W | Base byte address |
| vl | input | VL_W | Active element count |
| sew_code | input | 2 | Element width code, 8<<code bits |
| lmul_code | input | 2 | Register group multiplier code, 1<<code |
| seg_count_m1 | input | 3 | Segment field count minus one |
| use_mask | input | 1 | 1 = all elements active, 0 = mask snapshot applies |
| mem_size | input | 2 | Memory element size code, 1<<code bytes |
| load_signed | input | 1 | Sign-extend loaded data |
| is_store | input | 1 | 1 = store, 0 = load |
| mask_bits | input | VLEN | Mask register image |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Completion pulse |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | ADDR_W | Request byte address |
| mem_req_write | output | 1 | Request is a write |
| mem_req_size | output | 2 | Request size code |
| mem_req_wdata | output | DATA_W | Store data, right aligned |
| mem_rsp_valid | input | 1 | Load response valid |
| mem_rsp_data | input | DATA_W | Load response data, right aligned |
| rf_rd_en | output | 1 | Register file read enable |
| rf_rd_idx | output | IDX_W | Register file read element index |
| rf_rd_data | input | DATA_W | Read data, one cycle after enable |
| rf_we | output | 1 | Register file write enable |
| rf_widx | output | IDX_W | Register file write element index |
| rf_wdata | output | DATA_W | Register file write data |

## Verification
The hardest case to reach is a segmented store where `mem_req_ready` drops while the fetched element is on the request lines. Each field then needs a register read, a capture and a held request, and the held data must still match the right field group. The stimulus runs stores with several fields under a repeating ready-low pattern, and the bench checks that each stalled request matches its earlier value. Masked loads use a mask pattern that makes bit i*M differ between neighbouring elements for several element and group codes. That leaves skipped entries untouched next to written and tail-cleared entries.

// File: rtl/vseg_pkg.sv
package vseg_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_SCAN, S_FETCH, S_LATCH, S_REQ, S_RSP, S_WRITE, S_TAIL, S_DONE
  } seq_state_t;

  // Mask covering 1<<code bytes of a 64-bit lane.
  function automatic logic [63:0] width_mask(input logic [1:0] code);
    case (code)
      2'd0:    return 64'h0000_0000_0000_00FF;
      2'd1:    return 64'h0000_0000_0000_FFFF;
      2'd2:    return 64'h0000_0000_FFFF_FFFF;
      default: return 64'hFFFF_FFFF_FFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/vseg_geom.sv
module vseg_geom #(
  parameter int VLEN = 128,
  parameter int VL_W = $clog2(VLEN) + 1
) (
  input  logic [1:0]      sew_code,
  input  logic [1:0]      lmul_code,
  input  logic [2:0]      seg_m1,
  input  logic [1:0]      mem_size,
  output logic [VL_W-1:0] vmax,
  output logic [2:0]      mlen_log2,
  output logic [6:0]      seg_bytes
);
  localparam logic [VL_W-1:0] REG_BYTES = VL_W'(VLEN / 8);

  always_comb begin
    vmax      = (REG_BYTES << lmul_code) >> sew_code;
    mlen_log2 = 3'(sew_code) + 3'd3 - 3'(lmul_code);
    seg_bytes = (7'(seg_m1) + 7'd1) << mem_size;
  end
endmodule

// File: rtl/vseg_mask_pick.sv
module vseg_mask_pick #(
  parameter int VLEN = 128,
  parameter int VL_W = $clog2(VLEN) + 1
) (
  input  logic [VLEN-1:0] mask_img,
  input  logic [VL_W-1:0] elem,
  input  logic [2:0]      mlen_log2,
  output logic            bit_on
);
  localparam int PW = VL_W + 7;
  localparam int MI_W = $clog2(VLEN);
  localparam logic [PW-1:0] LIMIT = PW'(VLEN);

  logic [PW-1:0] pos;

  always_comb begin
    pos    = PW'(elem) << mlen_log2;
    bit_on = (pos < LIMIT) ? mask_img[pos[MI_W-1:0]] : 1'b0;
  end
endmodule

// File: rtl/vseg_load_extend.sv
module vseg_load_extend #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] raw,
  input  logic [1:0]        mem_size,
  input  logic              sign_ext,
  input  logic [1:0]        sew_code,
  output logic [DATA_W-1:0] ext
);
  import vseg_pkg::*;

  logic [DATA_W-1:0] widened;

  always_comb begin
    case (mem_size)
      2'd0: widened = {{(DATA_W-8){sign_ext & raw[7]}}, raw[7:0]};
      2'd1: widened = {{(DATA_W-16){sign_ext & raw[15]}}, raw[15:0]};
      2'd2: widened = {{(DATA_W-32){sign_ext & raw[31]}}, raw[31:0]};
      default: widened = raw;
    endcase
    ext = widened & DATA_W'(width_mask(sew_code));
  end
endmodule

// File: rtl/vseg_access_seq.sv
module vseg_access_seq #(
  parameter int ADDR_W = 32,
  parameter int VLEN   = 128,
  parameter int DATA_W = 64,
  parameter int VL_W   = $clog2(VLEN) + 1,
  parameter int IDX_W  = $clog2(8 * VLEN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [VL_W-1:0]   vl,
  input  logic [1:0]        sew_code,
  input  logic [1:0]        lmul_code,
  input  logic [2:0]        seg_count_m1,
  input  logic              use_mask,
  input  logic [1:0]        mem_size,
  input  logic              load_signed,
  input  logic              is_store,
  input  logic [VLEN-1:0]   mask_bits,
  output logic              busy,
  output logic              done,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic              mem_req_write,
  output logic [1:0]        mem_req_size,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic              rf_rd_en,
  output logic [IDX_W-1:0]  rf_rd_idx,
  input  logic [DATA_W-1:0] rf_rd_data,
  output logic              rf_we,
  output logic [IDX_W-1:0]  rf_widx,
  output logic [DATA_W-1:0] rf_wdata
);
  import vseg_pkg::*;

  seq_state_t        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [VL_W-1:0]   vl_q, i_q;
  logic [1:0]        sew_q, lmul_q, msz_q;
  logic [2:0]        nf_q, k_q;
  logic              all_on_q, sgn_q, st_q;
  logic [VLEN-1:0]   mask_q;
  logic [IDX_W-1:0]  fbase_q;
  logic [DATA_W-1:0] wdata_q, ldata_q;

  logic [VL_W-1:0]   vmax;
  logic [2:0]        mlen_log2;
  logic [6:0]        seg_bytes;
  logic              mask_hit, elem_on, last_elem, has_tail;
  logic [IDX_W-1:0]  elem_idx, vmax_idx;
  logic [ADDR_W-1:0] step_bytes;
  logic [DATA_W-1:0] ext_data;
  seq_state_t        fin_state, adv_state;
  logic [VL_W-1:0]   adv_i;
  logic [2:0]        adv_k;
  logic [IDX_W-1:0]  adv_fbase;

  vseg_geom #(.VLEN(VLEN), .VL_W(VL_W)) geom_i (
    .sew_code(sew_q), .lmul_code(lmul_q), .seg_m1(nf_q), .mem_size(msz_q),
    .vmax(vmax), .mlen_log2(mlen_log2), .seg_bytes(seg_bytes)
  );

  vseg_mask_pick #(.VLEN(VLEN), .VL_W(VL_W)) mask_i (
    .mask_img(mask_q), .elem(i_q), .mlen_log2(mlen_log2), .bit_on(mask_hit)
  );

  vseg_load_extend #(.DATA_W(DATA_W)) ext_i (
    .raw(ldata_q), .mem_size(msz_q), .sign_ext(sgn_q), .sew_code(sew_q),
    .ext(ext_data)
  );

  always_comb begin
    elem_idx   = IDX_W'(i_q) + fbase_q;
    vmax_idx   = IDX_W'(vmax);
    step_bytes = ADDR_W'(1) << msz_q;
    elem_on    = all_on_q | mask_hit;
    last_elem  = (i_q + VL_W'(1)) == vl_q;
    has_tail   = !st_q && (vl_q != vmax);
    fin_state  = has_tail ? S_TAIL : S_DONE;
    // Next position after one field transfer completes.
    if (k_q == nf_q) begin
      adv_k     = 3'd0;
      adv_fbase = '0;
      adv_i     = last_elem ? vl_q : i_q + VL_W'(1);
      adv_state = last_elem ? fin_state : S_SCAN;
    end else begin
      adv_k     = k_q + 3'd1;
      adv_fbase = fbase_q + vmax_idx;
      adv_i     = i_q;
      adv_state = st_q ? S_FETCH : S_REQ;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= S_IDLE;
      addr_q   <= '0;
      vl_q     <= '0;
      i_q      <= '0;
      k_q      <= '0;
      fbase_q  <= '0;
      sew_q    <= '0;
      lmul_q   <= '0;
      msz_q    <= '0;
      nf_q     <= '0;
      all_on_q <= 1'b0;
      sgn_q    <= 1'b0;
      st_q     <= 1'b0;
      mask_q   <= '0;
      wdata_q  <= '0;
      ldata_q  <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (start) begin
          addr_q   <= base_addr;
          vl_q     <= vl;
          sew_q    <= sew_code;
          lmul_q   <= lmul_code;
          nf_q     <= seg_count_m1;
          all_on_q <= use_mask;
          msz_q    <= mem_size;
          sgn_q    <= load_signed;
          st_q     <= is_store;
          mask_q   <= mask_bits;
          i_q      <= '0;
          k_q      <= '0;
          fbase_q  <= '0;
          state_q  <= (vl == '0) ? S_DONE : S_SCAN;
        end
        S_SCAN: begin
          if (elem_on) begin
            state_q <= st_q ? S_FETCH : S_REQ;
          end else begin
            addr_q <= addr_q + ADDR_W'(seg_bytes);
            if (last_elem) begin
              i_q     <= vl_q;
              state_q <= fin_state;
            end else begin
              i_q <= i_q + VL_W'(1);
            end
          end
        end
        S_FETCH: state_q <= S_LATCH;
        S_LATCH: begin
          wdata_q <= rf_rd_data & DATA_W'(width_mask(msz_q));
          state_q <= S_REQ;
        end
        S_REQ: if (mem_req_ready) begin
          if (st_q) begin
            addr_q  <= addr_q + step_bytes;
            i_q     <= adv_i;
            k_q     <= adv_k;
            fbase_q <= adv_fbase;
            state_q <= adv_state;
          end else begin
            state_q <= S_RSP;
          end
        end
        S_RSP: if (mem_rsp_valid) begin
          ldata_q <= mem_rsp_data;
          state_q <= S_WRITE;
        end
        S_WRITE: begin
          addr_q  <= addr_q + step_bytes;
          i_q     <= adv_i;
          k_q     <= adv_k;
          fbase_q <= adv_fbase;
          state_q <= adv_state;
        end
        S_TAIL: begin
          if (i_q == vmax - VL_W'(1)) begin
            if (k_q == nf_q) begin
              state_q <= S_DONE;
            end else begin
              k_q     <= k_q + 3'd1;
              fbase_q <= fbase_q + vmax_idx;
              i_q     <= vl_q;
            end
          end else begin
            i_q <= i_q + VL_W'(1);
          end
        end
        S_DONE:  state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    busy          = (state_q != S_IDLE);
    done          = (state_q == S_DONE);
    mem_req_valid = (state_q == S_REQ);
    mem_req_addr  = addr_q;
    mem_req_write = st_q;
    mem_req_size  = msz_q;
    mem_req_wdata = st_q ? wdata_q : '0;
    rf_rd_en      = (state_q == S_FETCH);
    rf_rd_idx     = elem_idx;
    rf_we         = (state_q == S_WRITE) || (state_q == S_TAIL);
    rf_widx       = elem_idx;
    rf_wdata      = (state_q == S_TAIL) ? '0 : ext_data;
  end

  // R9: request held unchanged while stalled
  p_req_hold_r9: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_wdata) && $stable(mem_req_size) && $stable(mem_req_write));

  // R4: empty operation finishes at once
  p_zero_vl_r4: assert property (@(posedge clk) disable iff (rst)
    start && !busy && (vl == '0) |=> done && !rf_we && !mem_req_valid);

  // R10: done is a lone pulse with no traffic beside it
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> !mem_req_valid && !rf_we && !rf_rd_en);

  // R8: no store data beyond the memory width
  p_store_narrow_r8: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && mem_req_write |->
      (mem_req_wdata & ~DATA_W'(width_mask(mem_req_size))) == '0);

  // R7: written elements carry nothing above the element width
  p_load_width_r7: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> (rf_wdata & ~DATA_W'(width_mask(sew_q))) == '0);

  // R6: stores never write the register file
  p_store_no_write_r6: assert property (@(posedge clk) disable iff (rst)
    busy && st_q |-> !rf_we);
endmodule

// File: tb/vseg_access_seq_tb_top.sv
module vseg_access_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int VLEN = 128;
  localparam int DATA_W = 64;
  localparam int VL_W = 8;
  localparam int IDX_W = 10;
  localparam int RFN = 1024;
  localparam logic [VLEN-1:0] MASK_PAT = 128'h0000_0000_0000_0001_0000_0000_0109_A5A6;

  typedef struct packed {
    logic        st;
    logic [1:0]  sew;
    logic [1:0]  lmul;
    logic [2:0]  nfm1;
    logic        all_on;
    logic [1:0]  mw;
    logic        sgn;
    logic [7:0]  vlen_act;
    logic [31:0] base;
    logic        stall;
    logic        poke;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd0, 2'd0, 3'd0, 1'b1, 2'd0, 1'b1, 8'd10, 32'h0000_0100, 1'b0, 1'b0},
    '{1'b0, 2'd2, 2'd1, 3'd2, 1'b1, 2'd0, 1'b1, 8'd5,  32'h0000_2003, 1'b1, 1'b0},
    '{1'b0, 2'd3, 2'd0, 3'd1, 1'b0, 2'd1, 1'b0, 8'd2,  32'h0000_3000, 1'b0, 1'b0},
    '{1'b1, 2'd1, 2'd0, 3'd1, 1'b1, 2'd0, 1'b0, 8'd6,  32'h0000_0400, 1'b1, 1'b0},
    '{1'b1, 2'd0, 2'd3, 3'd0, 1'b0, 2'd0, 1'b0, 8'd20, 32'h0000_0500, 1'b0, 1'b0},
    '{1'b0, 2'd1, 2'd2, 3'd1, 1'b0, 2'd1, 1'b1, 8'd7,  32'h0000_6002, 1'b1, 1'b0},
    '{1'b1, 2'd3, 2'd0, 3'd7, 1'b1, 2'd3, 1'b0, 8'd2,  32'h0000_7000, 1'b1, 1'b1},
    '{1'b0, 2'd0, 2'd0, 3'd0, 1'b1, 2'd0, 1'b0, 8'd16, 32'h0000_0800, 1'b0, 1'b0},
    '{1'b0, 2'd0, 2'd3, 3'd0, 1'b0, 2'd0, 1'b1, 8'd20, 32'h0000_9000, 1'b1, 1'b0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [ADDR_W-1:0] base_addr = '0;
  logic [VL_W-1:0] vl = '0;
  logic [1:0] sew_code = '0, lmul_code = '0, mem_size = '0;
  logic [2:0] seg_count_m1 = '0;
  logic use_mask = 1'b1, load_signed = 1'b0, is_store = 1'b0;
  logic [VLEN-1:0] mask_bits = MASK_PAT;
  logic busy, done, mem_req_valid, mem_req_write, rf_rd_en, rf_we;
  logic mem_req_ready = 1'b1;
  logic [ADDR_W-1:0] mem_req_addr;
  logic [1:0] mem_req_size;
  logic [DATA_W-1:0] mem_req_wdata, rf_wdata;
  logic mem_rsp_valid = 1'b0;
  logic [DATA_W-1:0] mem_rsp_data = '0;
  logic [IDX_W-1:0] rf_rd_idx, rf_widx;
  logic [DATA_W-1:0] rf_rd_data = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vseg_access_seq #(.ADDR_W(ADDR_W), .VLEN(VLEN), .DATA_W(DATA_W),
                    .VL_W(VL_W), .IDX_W(IDX_W)) dut_i (
    .clk(clk), .rst(rst), .start(start), .base_addr(base_addr), .vl(vl),
    .sew_code(sew_code), .lmul_code(lmul_code), .seg_count_m1(seg_count_m1),
    .use_mask(use_mask), .mem_size(mem_size), .load_signed(load_signed),
    .is_store(is_store), .mask_bits(mask_bits), .busy(busy), .done(done),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_req_write(mem_req_write),
    .mem_req_size(mem_req_size), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .rf_rd_en(rf_rd_en), .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data),
    .rf_we(rf_we), .rf_widx(rf_widx), .rf_wdata(rf_wdata)
  );

  int checks = 0, errors = 0;
  int cyc = 0;
  logic stall_en = 1'b0;
  logic [DATA_W-1:0] rf_m [RFN];
  logic [DATA_W-1:0] exp_rf [RFN];

  int n_rq = 0, n_we = 0, hold_err = 0;
  int done_cyc = -1, last_we_cyc = -1, last_fire_cyc = -1;
  logic [ADDR_W-1:0] rq_addr [256];
  logic rq_we [256];
  logic [1:0] rq_size [256];
  logic [DATA_W-1:0] rq_wdata [256];
  int n_ex = 0;
  logic [ADDR_W-1:0] ex_addr [256];
  logic [DATA_W-1:0] ex_wdata [256];

  logic rsp_pend = 1'b0;
  logic [ADDR_W-1:0] pend_addr = '0;
  logic [1:0] pend_size = '0;
  logic prev_wait = 1'b0;
  logic [ADDR_W-1:0] prev_addr = '0;
  logic [DATA_W-1:0] prev_wdata = '0;

  function automatic logic [7:0] mem_byte(input logic [ADDR_W-1:0] a);
    return 8'(a[7:0] * 8'd37) ^ a[15:8] ^ 8'hB1;
  endfunction

  function automatic logic [DATA_W-1:0] load_word(input logic [ADDR_W-1:0] a,
                                                 input logic [1:0] sz);
    logic [DATA_W-1:0] w = '0;
    for (int j = 0; j < 8; j++)
      w[j*8 +: 8] = (j < (1 << sz)) ? mem_byte(a + ADDR_W'(j)) : 8'hEE;
    return w;
  endfunction

  function automatic logic [DATA_W-1:0] rf_init(input int j);
    return 64'hC3A5_9F17_E2B4_8000 ^ (64'(j) * 64'h0001_0003_0107_0209);
  endfunction

  function automatic logic [DATA_W-1:0] low_bytes(input int n);
    return (n >= 8) ? '1 : ((64'd1 << (8 * n)) - 64'd1);
  endfunction

  always @(posedge clk) if (rf_rd_en) rf_rd_data <= rf_m[rf_rd_idx];

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (rsp_pend) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = load_word(pend_addr, pend_size);
      rsp_pend = 1'b0;
    end else begin
      mem_rsp_valid = 1'b0;
    end
    mem_req_ready = stall_en ? ((cyc % 3) != 1) : 1'b1;
    if (mem_req_valid) begin
      if (prev_wait && (mem_req_addr != prev_addr || mem_req_wdata != prev_wdata))
        hold_err = hold_err + 1;
      if (mem_req_ready) begin
        if (n_rq < 256) begin
          rq_addr[n_rq] = mem_req_addr; rq_we[n_rq] = mem_req_write;
          rq_size[n_rq] = mem_req_size; rq_wdata[n_rq] = mem_req_wdata;
        end
        n_rq = n_rq + 1;
        last_fire_cyc = cyc;
        if (!mem_req_write) begin
          rsp_pend = 1'b1; pend_addr = mem_req_addr; pend_size = mem_req_size;
        end
        prev_wait = 1'b0;
      end else begin
        prev_wait = 1'b1; prev_addr = mem_req_addr; prev_wdata = mem_req_wdata;
      end
    end
    if (rf_we) begin
      rf_m[rf_widx] = rf_wdata;
      n_we = n_we + 1;
      last_we_cyc = cyc;
    end
    if (done && done_cyc < 0) done_cyc = cyc;
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic clear_logs();
    n_rq = 0; n_we = 0; done_cyc = -1; last_we_cyc = -1; last_fire_cyc = -1;
    for (int j = 0; j < RFN; j++) begin
      rf_m[j] = rf_init(j);
      exp_rf[j] = rf_init(j);
    end
  endtask

  task automatic run_vec(input vec_t t, input int vid);
    int vmax, mlen, nf, msz, wait_n, bad, bad_idx;
    bit last_on;
    logic [DATA_W-1:0] w;
    clear_logs();
    vmax = ((VLEN / 8) << t.lmul) >> t.sew;
    mlen = 1 << (t.sew + 3 - t.lmul);
    nf   = t.nfm1 + 1;
    msz  = 1 << t.mw;
    n_ex = 0;
    last_on = 1'b0;
    for (int i = 0; i < t.vlen_act; i++) begin
      bit on = t.all_on || MASK_PAT[i * mlen];
      if (i == t.vlen_act - 1) last_on = on;
      if (on) begin
        for (int k = 0; k < nf; k++) begin
          ex_addr[n_ex] = t.base + ADDR_W'((i * nf + k) * msz);
          ex_wdata[n_ex] = t.st ? (rf_init(i + k * vmax) & low_bytes(msz)) : '0;
          if (!t.st) begin
            w = load_word(ex_addr[n_ex], t.mw) & low_bytes(msz);
            if (t.sgn && msz < 8 && w[8 * msz - 1]) w = w | ~low_bytes(msz);
            exp_rf[i + k * vmax] = w & low_bytes(1 << t.sew);
          end
          n_ex = n_ex + 1;
        end
      end
    end
    if (!t.st)
      for (int k = 0; k < nf; k++)
        for (int i = t.vlen_act; i < vmax; i++) exp_rf[i + k * vmax] = '0;

    stall_en = t.stall;
    @(negedge clk);
    base_addr = t.base; vl = t.vlen_act; sew_code = t.sew; lmul_code = t.lmul;
    seg_count_m1 = t.nfm1; use_mask = t.all_on; mem_size = t.mw;
    load_signed = t.sgn; is_store = t.st; mask_bits = MASK_PAT; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (t.poke) begin
      repeat (3) @(negedge clk);
      base_addr = 32'hDEAD_0000; vl = '0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait_n = 0;
    while (!done && wait_n < 20000) begin
      @(negedge clk);
      wait_n = wait_n + 1;
    end
    check(done, "R10", $sformatf("vec %0d done seen", vid), 64'(done), 64'd1);
    repeat (2) @(negedge clk);

    check(n_rq == n_ex, "R1", $sformatf("vec %0d request count", vid),
          64'(n_rq), 64'(n_ex));
    for (int r = 0; r < n_ex && r < n_rq; r++) begin
      check(rq_addr[r] == ex_addr[r] && rq_we[r] == t.st && rq_size[r] == t.mw,
            "R1", $sformatf("vec %0d req %0d addr", vid, r),
            64'(rq_addr[r]), 64'(ex_addr[r]));
      if (t.st)
        check(rq_wdata[r] == ex_wdata[r], "R8 R11",
              $sformatf("vec %0d req %0d store data", vid, r),
              rq_wdata[r], ex_wdata[r]);
    end
    bad = 0; bad_idx = 0;
    for (int j = 0; j < RFN; j++)
      if (rf_m[j] !== exp_rf[j]) begin
        if (bad == 0) bad_idx = j;
        bad = bad + 1;
      end
    check(bad == 0, "R2 R3 R5 R6 R7",
          $sformatf("vec %0d reg file index %0d", vid, bad_idx),
          rf_m[bad_idx], exp_rf[bad_idx]);
    if (!t.st && t.vlen_act < vmax)
      check(done_cyc == last_we_cyc + 1, "R10",
            $sformatf("vec %0d done after tail", vid),
            64'(done_cyc), 64'(last_we_cyc + 1));
    if (t.st && last_on)
      check(done_cyc == last_fire_cyc + 1, "R10",
            $sformatf("vec %0d done after last store", vid),
            64'(done_cyc), 64'(last_fire_cyc + 1));
    if (t.st)
      check(n_we == 0, "R6", $sformatf("vec %0d store wrote reg file", vid),
            64'(n_we), 64'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks = checks + 1;
    errors = errors + 1;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    clear_logs();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state
    check(!busy && !done && !mem_req_valid && !rf_we && !rf_rd_en, "R10",
          "reset outputs idle",
          {59'd0, busy, done, mem_req_valid, rf_we, rf_rd_en}, 64'd0);

    // R4: empty operation
    clear_logs();
    @(negedge clk);
    base_addr = 32'h1234; vl = '0; is_store = 1'b0; use_mask = 1'b1;
    sew_code = 2'd0; lmul_code = 2'd0; seg_count_m1 = 3'd2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done, "R4", "done one cycle after empty start", 64'(done), 64'd1);
    repeat (3) @(negedge clk);
    check(n_rq == 0 && n_we == 0, "R4", "no traffic for empty op",
          64'(n_rq + n_we), 64'd0);

    for (int v = 0; v < NV; v++) run_vec(VECS[v], v);

    check(hold_err == 0, "R9", "stalled request changed", 64'(hold_err), 64'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule